// File: doc/BRIEF.md
# Receive FIFO Fill-Level Interrupt Unit

This unit sits beside a receive FIFO. It compares the FIFO's fill level against a threshold that software programs, and it raises an interrupt line when the FIFO holds enough data. The threshold count is scaled by the FIFO depth fixed at elaboration. One count stands for 1 byte on FIFOs of 64 bytes or less, 2 bytes on a 128-byte FIFO and 4 bytes on a 256-byte FIFO. This lets a 6-bit field reach close to the top of the deepest FIFO.

The ready condition is not latched. It follows the fill level one clock late and has no clear of its own. Software therefore turns off its enable bit once it has taken the interrupt. Two event inputs, receive overrun and transmit underrun, set sticky pending bits. Software clears each of these by writing 1 into a clear register and then writing 0. The FIFO storage and the serial shifter live elsewhere, and the fill level arrives as an input.

Top module: `rx_rdy_irq`

## Requirements
- R1: After reset, all readable registers read 0 and `irq` is low.
- R2: The threshold field sits at bits 16:11 of the config register (word offset 0x0). It reads back as written, and all other bits of that register read 0.
- R3: The threshold in bytes is the field value times 1 when FIFO_DEPTH <= 64, times 2 when FIFO_DEPTH is 128, and times 4 when FIFO_DEPTH is 256.
- R4: Status bit 0 (word offset 0x8) is the ready bit. It reads 1 one clock after `fifo_level` is at or above the scaled, nonzero threshold. It falls one clock after the condition fails, including when the threshold is raised.
- R5: A threshold field of 0 never sets the ready bit.
- R6: Enable bit 0 (word offset 0x4) gates the ready bit onto `irq`. Clearing enable bit 0 removes that interrupt after the write. Writing 1 to clear-register bit 0 has no effect on the ready bit.
- R7: A pulse on `ovr_evt` sets status bit 1, and a pulse on `unr_evt` sets status bit 2. Both bits stay set until they are cleared.
- R8: Bits 2:1 of the clear register (word offset 0xC) are read back as written. While one of them holds 1, the matching pending bit is forced to 0 at each clock, and events that arrive during that time are lost. Writing the bit back to 0 lets the next event set the pending bit again.
- R9: Enable bits 1 and 2 gate status bits 1 and 2 onto `irq`. `irq` is the OR of all three gated sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address; bits 3:2 pick the word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| fifo_level | input | $clog2(FIFO_DEPTH)+1 | Current receive FIFO fill in bytes |
| ovr_evt | input | 1 | Receive overrun event pulse |
| unr_evt | input | 1 | Transmit underrun event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same clock: an event pulse setting a pending bit, and a held clear bit forcing that pending bit to zero. The bench pulses an overrun in the same cycle as the write that raises the clear bit. It then pulses another overrun while the bit is held, and expects status bit 1 to read 0 both times. After the clear bit is written back to 0, one more pulse must set the pending bit. A second pairing is a threshold write that lands while the fill level sits above the old threshold. Here the ready bit must still read 1 right after the write and read 0 exactly one cycle later.

// File: rtl/rx_rdy_irq.sv
module rx_rdy_irq #(
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int THR_LSB = 11,
  parameter int THR_W = 6,
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              ovr_evt,
  input  logic              unr_evt,
  output logic              irq
);
  localparam int SCALE_SH = (FIFO_DEPTH >= 256) ? 2 : (FIFO_DEPTH >= 128) ? 1 : 0;
  localparam int CMP_W = LVL_W + THR_W + 2;
  localparam logic [1:0] W_CFG = 2'd0, W_EN = 2'd1, W_STAT = 2'd2, W_CLR = 2'd3;

  logic [THR_W-1:0] thr_q;
  logic [2:0]       en_q;
  logic [1:0]       clr_q;
  logic [1:0]       pend_q;
  logic             rdy_q;
  logic [1:0]       widx;
  logic [CMP_W-1:0] thr_bytes, lvl_ext;

  assign widx      = reg_addr[3:2];
  assign thr_bytes = CMP_W'(thr_q) << SCALE_SH;
  assign lvl_ext   = CMP_W'(fifo_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      en_q  <= '0;
      clr_q <= '0;
    end else if (reg_wr) begin
      case (widx)
        W_CFG:   thr_q <= reg_wdata[THR_LSB +: THR_W];
        W_EN:    en_q  <= reg_wdata[2:0];
        W_CLR:   clr_q <= reg_wdata[2:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= (thr_q != '0) && (lvl_ext >= thr_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q[0] <= clr_q[0] ? 1'b0 : (pend_q[0] | ovr_evt);
      pend_q[1] <= clr_q[1] ? 1'b0 : (pend_q[1] | unr_evt);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (widx)
      W_CFG:  reg_rdata[THR_LSB +: THR_W] = thr_q;
      W_EN:   reg_rdata[2:0] = en_q;
      W_STAT: reg_rdata[2:0] = {pend_q, rdy_q};
      W_CLR:  reg_rdata[2:1] = clr_q;
      default: ;
    endcase
  end

  assign irq = (rdy_q & en_q[0]) | (pend_q[0] & en_q[1]) | (pend_q[1] & en_q[2]);
endmodule

// File: rtl/rx_rdy_irq_chk.sv
module rx_rdy_irq_chk #(
  parameter int THR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [THR_W-1:0] thr,
  input logic [2:0]       en,
  input logic [1:0]       clr,
  input logic [1:0]       pend,
  input logic             rdy,
  input logic             ovr_evt,
  input logic             irq
);
  assert_zero_thr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> !rdy);
  assert_rdy_drives_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && en[0]) |-> irq);
  assert_no_source_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && pend == 2'b00) |-> !irq);
  assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clr[0]) |=> pend[0]);
  assert_held_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> !pend[0]);
endmodule

bind rx_rdy_irq rx_rdy_irq_chk #(.THR_W(THR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .thr(thr_q), .en(en_q), .clr(clr_q),
  .pend(pend_q), .rdy(rdy_q), .ovr_evt(ovr_evt), .irq(irq)
);

// File: tb/rx_rdy_irq_tb_top.sv
module rx_rdy_irq_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] rd64, rd128, rd256;
  logic [6:0] lvl64 = 0;
  logic [7:0] lvl128 = 0;
  logic [8:0] lvl256 = 0;
  logic ovr = 0, unr = 0;
  logic irq64, irq128, irq256;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  rx_rdy_irq #(.FIFO_DEPTH(64)) dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd64), .fifo_level(lvl64),
    .ovr_evt(ovr), .unr_evt(unr), .irq(irq64));
  rx_rdy_irq #(.FIFO_DEPTH(128)) dut128_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd128), .fifo_level(lvl128),
    .ovr_evt(ovr), .unr_evt(unr), .irq(irq128));
  rx_rdy_irq #(.FIFO_DEPTH(256)) dut256_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd256), .fifo_level(lvl256),
    .ovr_evt(ovr), .unr_evt(unr), .irq(irq256));

  function automatic bit exp_rdy(int thr, int lvl, int unit);
    return (thr != 0) && (lvl >= thr * unit);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d64,
                    output logic [31:0] d128, output logic [31:0] d256);
    reg_addr = a; #1;
    d64 = rd64; d128 = rd128; d256 = rd256;
  endtask

  task automatic set_thr(input int t);
    wr(4'h0, 32'(t) << 11);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c;
    void'($urandom(32'h5eed));
    #22 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      rd(4'(w * 4), a, b, c);
      chk("R1 rdata", a | b | c, 0);
    end
    chk("R1 irq", irq64 | irq128 | irq256, 0);

    // R2 field position and readback
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, a, b, c);
    chk("R2 cfg readback", a, 32'h0001_F800);
    set_thr(5);
    rd(4'h0, a, b, c);
    chk("R2 thr=5", a, 32'h0000_2800);

    // R3 scaling: thr=10 -> 10/20/40 bytes
    set_thr(10);
    lvl64 = 10; lvl128 = 19; lvl256 = 39;
    @(negedge clk); @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R3 d64 at 10", a[0], 1);
    chk("R3 d128 at 19", b[0], 0);
    chk("R3 d256 at 39", c[0], 0);
    lvl64 = 9; lvl128 = 20; lvl256 = 40;
    @(negedge clk); @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R3 d64 at 9", a[0], 0);
    chk("R3 d128 at 20", b[0], 1);
    chk("R3 d256 at 40", c[0], 1);

    // R4 threshold raise drops ready exactly one cycle later
    lvl64 = 20;
    @(negedge clk); @(negedge clk);
    set_thr(30);
    rd(4'h8, a, b, c);
    chk("R4 ready still set right after write", a[0], 1);
    @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R4 ready dropped next cycle", a[0], 0);

    // R5 zero threshold
    set_thr(0);
    lvl64 = 64; lvl128 = 128; lvl256 = 256;
    @(negedge clk); @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R5 zero thr", {a[0], b[0], c[0]}, 0);

    // R6 enable gating, no effect of clear bit 0
    set_thr(4);
    @(negedge clk); @(negedge clk);
    chk("R6 irq off while disabled", irq64, 0);
    wr(4'h4, 32'h1);
    chk("R6 irq on when enabled", irq64, 1);
    wr(4'hC, 32'h1);
    @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R6 clear bit0 no effect on ready", a[0], 1);
    chk("R6 irq stays with clear bit0", irq64, 1);
    wr(4'hC, 32'h0);
    wr(4'h4, 32'h0);
    chk("R6 irq removed by enable clear", irq64, 0);

    // R7 sticky events
    lvl64 = 0; lvl128 = 0; lvl256 = 0;
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    @(negedge clk); @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R7 overrun pending", a[2:0], 3'b010);
    @(negedge clk); unr = 1; @(negedge clk); unr = 0;
    rd(4'h8, a, b, c);
    chk("R7 underrun pending", a[2:0], 3'b110);

    // R9 irq from pending sources
    wr(4'h4, 32'h4);
    chk("R9 irq from underrun", irq64, 1);
    wr(4'h4, 32'h2);
    chk("R9 irq from overrun", irq64, 1);

    // R8 clear protocol and collision with event
    wr(4'hC, 32'h6);
    rd(4'hC, a, b, c);
    chk("R8 clear readback", a, 32'h6);
    @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R8 pendings cleared", a[2:1], 0);
    chk("R9 irq gone after clear", irq64, 0);
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R8 event lost while clear held", a[1], 0);
    wr(4'hC, 32'h0);
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    rd(4'h8, a, b, c);
    chk("R8 event sets after release", a[1], 1);
    // same cycle: clear write and event, clear bit stays held
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'hC; reg_wdata = 32'h2; ovr = 1;
    @(negedge clk);
    reg_wr = 0; ovr = 0;
    @(negedge clk);
    rd(4'h8, a, b, c);
    chk("R8 collision clear wins", a[1], 0);
    wr(4'hC, 32'h0);

    // Random: R3/R4 across all depths
    for (int i = 0; i < 40; i++) begin
      int t;
      t = int'($urandom_range(0, 63));
      set_thr(t);
      lvl64 = 7'($urandom_range(0, 63));
      lvl128 = 8'($urandom_range(0, 127));
      lvl256 = 9'($urandom_range(0, 255));
      @(negedge clk); @(negedge clk);
      rd(4'h8, a, b, c);
      chk("R3/R4 random d64", a[0], exp_rdy(t, int'(lvl64), 1));
      chk("R3/R4 random d128", b[0], exp_rdy(t, int'(lvl128), 2));
      chk("R3/R4 random d256", c[0], exp_rdy(t, int'(lvl256), 4));
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule